// File: doc/BRIEF.md
# Windowed Frequency and Period Meter

This block measures how fast rising edges arrive on encoder track A. A frequency measurement opens on a rising edge of A. It runs for at least a programmable window, set in microseconds. After the window has elapsed it stays open until the next rising edge of A, so the result always covers a whole number of A periods. At that closing edge the block publishes two values: the number of A periods, and the elapsed time in 100 ns ticks. A one-clock done strobe marks each new result. The division into scaled hertz is left to downstream logic. The closing edge also opens the next window, so measurement is continuous while edges keep arriving.

A second path measures the time between consecutive rising edges of A in 100 ns ticks. It publishes each value with its own done strobe. A gate input stops the frequency path but not the period path. A restart input abandons a window in progress and keeps the last published frequency result. If no edge closes an open window within the wait limit, the frequency outputs are cleared. If A stays quiet for the no-edge limit, both the frequency and the period outputs are cleared. The 100 ns tick comes from the system clock through a parameterized prescaler.

Top module: `freq_period_meter`

## Requirements
- R1: After reset, `freq_edges`, `freq_time` and `period_val` are zero, and `freq_done` and `period_done` are low.
- R2: Time values are counted in ticks, with one tick every `CLK_DIV` clocks. For edges spaced N·`CLK_DIV` clocks apart, the measured time is exactly N ticks.
- R3: The window time is `win_us`·`TICKS_PER_US` ticks. Rising edges of A are spaced P ticks apart, and k is the smallest integer with k·P at least the window time. A window opened on an edge closes on edge k after it. It publishes `freq_edges` = k and `freq_time` = k·P, with `freq_done` high for exactly one clock.
- R4: The closing edge of a window also opens the next one, so a steady edge train gives a result every k edges.
- R5: A `win_us` value of 0 is treated as 1 µs.
- R6: An open window may receive no edge within `WAIT_TICKS` ticks after its window time has elapsed. In that case `freq_edges` and `freq_time` are cleared to zero, no `freq_done` pulse is given, and the next edge opens a new window.
- R7: While `gate_block` is high, edges on A open no window and produce no frequency result. Period measurement continues.
- R8: A one-clock `restart` pulse abandons the window in progress and keeps the published frequency values. The next rising edge of A opens a fresh window.
- R9: `period_val` is the number of ticks between two consecutive rising edges of A, published with a one-clock `period_done`. The first edge after reset or after a no-edge timeout gives no period result.
- R10: After `NOEDGE_TICKS` ticks with no rising edge of A following a measured edge, `period_val`, `freq_edges` and `freq_time` are cleared to zero.
- R11: `freq_done` and `period_done` are never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trk_a | input | 1 | Track A, already synchronized to clk |
| gate_block | input | 1 | High stops the frequency path |
| restart | input | 1 | Pulse that abandons the current frequency window |
| win_us | input | WIN_W | Minimum window length in µs (0 read as 1) |
| freq_edges | output | CNT_W | A periods in the last completed window |
| freq_time | output | TIME_W | Ticks spanned by the last completed window |
| freq_done | output | 1 | One-clock strobe for a new frequency result |
| period_val | output | PER_W | Ticks between the last two rising edges of A |
| period_done | output | 1 | One-clock strobe for a new period result |

## Verification
The bench drives a steady A train that is longer than one window. A design that counted only edges inside the window, or that did not stretch to the next edge, would report three periods and 90 ticks where four periods and 120 ticks are due. It then holds A quiet to reach the wait limit and later the no-edge limit, first with the frequency path in a window and then after a restart. A design that confused the two limits, cleared on restart, or kept waiting after an abandoned window would show the wrong values at the sampled points. A gated train must still give period results but no frequency result. A zero window must act as 1 µs; a design that took it literally would close on the first edge after the start, not the second.

// File: rtl/fpm_pkg.sv
// Shared types for the windowed frequency and period meter.
// Assumes: nothing beyond IEEE 1800-2017.
package fpm_pkg;
    // Frequency path states: waiting for an opening edge, or inside a window.
    typedef enum logic [0:0] {
        FM_ARM = 1'b0,
        FM_RUN = 1'b1
    } fm_state_t;
endpackage

// File: rtl/fpm_tick_gen.sv
// Prescaler producing a one-clock tick every CLK_DIV clocks (the 100 ns base).
// Assumes: CLK_DIV >= 1; counts from reset release.
module fpm_tick_gen #(
    parameter int CLK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(CLK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);
            logic [DIV_W-1:0] div_q;

            // Free-running divider counter wrapping at CLK_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);

            // R2: with a divider above one, ticks are isolated clocks.
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/fpm_period_unit.sv
// Measures ticks between consecutive rising edges of track A and raises a
// stale flag when a measured edge is followed by NOEDGE_TICKS quiet ticks.
// Assumes: a_rise is a one-clock pulse; tick comes from fpm_tick_gen.
module fpm_period_unit #(
    parameter int PER_W        = 32,
    parameter int NOEDGE_TICKS = 16_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             a_rise,
    output logic             stale,
    output logic [PER_W-1:0] period_val,
    output logic             period_done
);
    localparam logic [PER_W-1:0] LIMIT = PER_W'(NOEDGE_TICKS);

    logic [PER_W-1:0] span_q;
    logic [PER_W-1:0] span_nx;
    logic             armed_q;

    assign span_nx = span_q + {{(PER_W-1){1'b0}}, tick};
    assign stale   = armed_q && !a_rise && (span_nx >= LIMIT);

    // Span counter, arming flag and published period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q      <= '0;
            armed_q     <= 1'b0;
            period_val  <= '0;
            period_done <= 1'b0;
        end else begin
            period_done <= 1'b0;
            if (a_rise) begin
                if (armed_q) begin
                    period_val  <= span_nx;
                    period_done <= 1'b1;
                end
                span_q  <= '0;
                armed_q <= 1'b1;
            end else if (stale) begin
                period_val <= '0;
                armed_q    <= 1'b0;
                span_q     <= '0;
            end else if (armed_q) begin
                span_q <= span_nx;
            end
        end
    end

    // R9: an edge seen while unarmed never yields a period result.
    assert_first_edge_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rise && !armed_q) |=> !period_done);
    // R10: a no-edge timeout leaves the period output at zero.
    assert_stale_clears_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> (period_val == '0));
    // R11: period strobes are single clocks.
    assert_period_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> !period_done);
endmodule

// File: rtl/fpm_window_unit.sv
// Gated frequency window: opens on an A edge, runs at least the programmed
// window, closes on the next A edge, and publishes periods and ticks.
// Assumes: a_rise is a one-clock pulse; stale comes from fpm_period_unit.
module fpm_window_unit
    import fpm_pkg::*;
#(
    parameter int WIN_W        = 16,
    parameter int CNT_W        = 32,
    parameter int TIME_W       = 32,
    parameter int TICKS_PER_US = 10,
    parameter int WAIT_TICKS   = 16_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              a_rise,
    input  logic              gate_block,
    input  logic              restart,
    input  logic              stale,
    input  logic [WIN_W-1:0]  win_us,
    output logic [CNT_W-1:0]  freq_edges,
    output logic [TIME_W-1:0] freq_time,
    output logic              freq_done
);
    localparam logic [TIME_W-1:0] TICK_MUL = TIME_W'(TICKS_PER_US);
    localparam logic [TIME_W-1:0] WAIT_LIM = TIME_W'(WAIT_TICKS);

    fm_state_t         state_q;
    logic [TIME_W-1:0] elap_q;
    logic [TIME_W-1:0] elap_nx;
    logic [CNT_W-1:0]  edges_q;
    logic [WIN_W-1:0]  win_eff;
    logic [TIME_W-1:0] win_ticks;
    logic              win_met;
    logic              expire;
    logic              hold_off;

    // Window length in ticks, with a zero setting read as 1 us.
    always_comb begin
        win_eff   = (win_us == '0) ? WIN_W'(1) : win_us;
        win_ticks = TIME_W'(win_eff) * TICK_MUL;
    end

    assign elap_nx  = elap_q + {{(TIME_W-1){1'b0}}, tick};
    assign win_met  = (elap_nx >= win_ticks);
    assign expire   = (state_q == FM_RUN) && !a_rise && (elap_nx >= win_ticks + WAIT_LIM);
    assign hold_off = restart || gate_block || stale;

    // Window state, running counts and published result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FM_ARM;
            elap_q     <= '0;
            edges_q    <= '0;
            freq_edges <= '0;
            freq_time  <= '0;
            freq_done  <= 1'b0;
        end else begin
            freq_done <= 1'b0;
            if (stale) begin
                freq_edges <= '0;
                freq_time  <= '0;
            end
            if (hold_off) begin
                state_q <= FM_ARM;
            end else begin
                unique case (state_q)
                    FM_ARM: begin
                        if (a_rise) begin
                            state_q <= FM_RUN;
                            elap_q  <= '0;
                            edges_q <= '0;
                        end
                    end
                    FM_RUN: begin
                        if (a_rise && win_met) begin
                            freq_edges <= edges_q + 1'b1;
                            freq_time  <= elap_nx;
                            freq_done  <= 1'b1;
                            elap_q     <= '0;
                            edges_q    <= '0;
                        end else if (a_rise) begin
                            edges_q <= edges_q + 1'b1;
                            elap_q  <= elap_nx;
                        end else if (expire) begin
                            freq_edges <= '0;
                            freq_time  <= '0;
                            state_q    <= FM_ARM;
                        end else begin
                            elap_q <= elap_nx;
                        end
                    end
                    default: state_q <= FM_ARM;
                endcase
            end
        end
    end

    // R3: a published window spans at least the programmed window.
    assert_result_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freq_done |-> ((freq_time >= $past(win_ticks)) && (freq_edges != '0)));
    // R6: an expired wait clears the frequency outputs.
    assert_wait_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !hold_off) |=> ((freq_edges == '0) && (freq_time == '0) && !freq_done));
    // R8: a restart keeps the published frequency values.
    assert_restart_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !stale) |=> ($stable(freq_edges) && $stable(freq_time) && !freq_done));
    // R10: a no-edge timeout clears the frequency outputs too.
    assert_stale_clears_freq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> ((freq_edges == '0) && (freq_time == '0)));
    // R11: frequency strobes are single clocks.
    assert_freq_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        freq_done |=> !freq_done);
endmodule

// File: rtl/freq_period_meter.sv
// Top level: edge detection on track A, 100 ns prescaler, frequency window
// unit and period unit. Outputs the raw numerator/denominator pair.
// Assumes: trk_a, gate_block and restart are synchronous to clk.
module freq_period_meter #(
    parameter int CLK_DIV      = 10,
    parameter int TICKS_PER_US = 10,
    parameter int WIN_W        = 16,
    parameter int CNT_W        = 32,
    parameter int TIME_W       = 32,
    parameter int PER_W        = 32,
    parameter int WAIT_TICKS   = 16_000_000,
    parameter int NOEDGE_TICKS = 16_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trk_a,
    input  logic              gate_block,
    input  logic              restart,
    input  logic [WIN_W-1:0]  win_us,
    output logic [CNT_W-1:0]  freq_edges,
    output logic [TIME_W-1:0] freq_time,
    output logic              freq_done,
    output logic [PER_W-1:0]  period_val,
    output logic              period_done
);
    logic a_q;
    logic a_rise;
    logic tick;
    logic stale;

    // Previous sample of track A for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= 1'b0;
        else        a_q <= trk_a;
    end

    assign a_rise = trk_a && !a_q;

    fpm_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fpm_period_unit #(
        .PER_W        (PER_W),
        .NOEDGE_TICKS (NOEDGE_TICKS)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .a_rise      (a_rise),
        .stale       (stale),
        .period_val  (period_val),
        .period_done (period_done)
    );

    fpm_window_unit #(
        .WIN_W        (WIN_W),
        .CNT_W        (CNT_W),
        .TIME_W       (TIME_W),
        .TICKS_PER_US (TICKS_PER_US),
        .WAIT_TICKS   (WAIT_TICKS)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .a_rise     (a_rise),
        .gate_block (gate_block),
        .restart    (restart),
        .stale      (stale),
        .win_us     (win_us),
        .freq_edges (freq_edges),
        .freq_time  (freq_time),
        .freq_done  (freq_done)
    );

    // R7: no frequency result follows a cycle with the gate closed.
    assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_done |-> !$past(gate_block));
    // R1: outputs sit at zero in the cycle after reset is released.
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> ((freq_edges == '0) && (period_val == '0) && !freq_done && !period_done));
endmodule

// File: tb/tb_freq_period_meter.sv
// Directed bench for freq_period_meter: one task per scenario.
module tb_freq_period_meter;
    localparam int DIV  = 10;
    localparam int WAIT = 300;
    localparam int NOE  = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trk_a = 1'b0;
    logic        gate_block = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] win_us = 16'd10;
    logic [31:0] freq_edges;
    logic [31:0] freq_time;
    logic        freq_done;
    logic [31:0] period_val;
    logic        period_done;

    int total = 0;
    int bad   = 0;
    int n_fd  = 0;
    int n_pd  = 0;

    freq_period_meter #(
        .CLK_DIV      (DIV),
        .WAIT_TICKS   (WAIT),
        .NOEDGE_TICKS (NOE)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trk_a       (trk_a),
        .gate_block  (gate_block),
        .restart     (restart),
        .win_us      (win_us),
        .freq_edges  (freq_edges),
        .freq_time   (freq_time),
        .freq_done   (freq_done),
        .period_val  (period_val),
        .period_done (period_done)
    );

    always #5 clk = ~clk;

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && freq_done)   n_fd++;
        if (rst_n && period_done) n_pd++;
    end

    task automatic chk(input string req, input longint got, input longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    // n rising edges of A spaced p clocks; optional restart pulse after edge rs.
    task automatic train(input int p, input int n, input int rs);
        for (int i = 1; i <= n; i++) begin
            trk_a = 1'b1;
            repeat (p / 2) @(negedge clk);
            trk_a = 1'b0;
            if (i == rs) begin
                repeat (p / 4) @(negedge clk);
                restart = 1'b1;
                @(negedge clk);
                restart = 1'b0;
                repeat (p - p / 2 - p / 4 - 1) @(negedge clk);
            end else begin
                repeat (p - p / 2) @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 freq_edges", freq_edges, 0);
        chk("R1 freq_time", freq_time, 0);
        chk("R1 period_val", period_val, 0);
        chk("R1 freq_done", freq_done, 0);
        chk("R1 period_done", period_done, 0);
    endtask

    // 10 us window, 30-tick period: results of 4 periods / 120 ticks.
    task automatic t_steady;
        int f0 = n_fd;
        int p0 = n_pd;
        win_us = 16'd10;
        train(300, 9, -1);
        chk("R3 edges", freq_edges, 4);
        chk("R2 R3 time", freq_time, 120);
        chk("R4 back-to-back count", n_fd - f0, 2);
        chk("R9 period value", period_val, 30);
        chk("R9 first edge silent", n_pd - p0, 8);
        wait_ticks(420);
        chk("R6 edges cleared", freq_edges, 0);
        chk("R6 time cleared", freq_time, 0);
        chk("R6 no strobe", n_fd - f0, 2);
        chk("R6 period kept", period_val, 30);
        wait_ticks(1100);
        chk("R10 period cleared", period_val, 0);
    endtask

    // Zero window acts as 1 us (10 ticks); 5-tick period closes on 2nd edge.
    task automatic t_zero_window;
        int f0 = n_fd;
        win_us = 16'd0;
        train(50, 3, -1);
        chk("R5 result count", n_fd - f0, 1);
        chk("R5 edges", freq_edges, 2);
        chk("R5 time", freq_time, 10);
        wait_ticks(1600);
        win_us = 16'd10;
    endtask

    // Gate closed: periods measured, no frequency result.
    task automatic t_gate;
        int f0 = n_fd;
        int p0 = n_pd;
        gate_block = 1'b1;
        train(300, 6, -1);
        chk("R7 no freq result", n_fd - f0, 0);
        chk("R7 freq held", freq_edges, 0);
        chk("R7 periods continue", n_pd - p0, 5);
        chk("R7 period value", period_val, 30);
        gate_block = 1'b0;
        wait_ticks(1600);
    endtask

    // Restart after edge 7 drops the window; value held until no-edge timeout.
    task automatic t_restart;
        int f0 = n_fd;
        train(300, 11, 7);
        chk("R8 only first result", n_fd - f0, 1);
        chk("R8 edges held", freq_edges, 4);
        chk("R8 time held", freq_time, 120);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        wait_ticks(570);
        chk("R8 held past wait", freq_edges, 4);
        chk("R8 time past wait", freq_time, 120);
        chk("R9 period", period_val, 30);
        wait_ticks(1000);
        chk("R10 freq cleared", freq_edges, 0);
        chk("R10 time cleared", freq_time, 0);
        chk("R10 period cleared", period_val, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_steady();
        t_zero_window();
        t_gate();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule